// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block fades a running stereo PCM stream to silence and back without stopping the stream. Each sample period is marked by a one-cycle strobe, and a left and a right signed sample arrive with it. Both channels share one internal gain index. While mute is requested, the index counts down toward zero. Otherwise it counts toward the programmed attenuation code. It moves one step every fixed number of sample strobes, so the length of a full fade grows with the programmed code.

A mute request is raised by either of two sources: a dedicated pin or a control bit. If the request is dropped part-way through a fade, the index turns round from wherever it stands. It then climbs back at the same rate. Each output sample is its input scaled by a linear gain looked up from the index, rounded toward zero and registered. A flag reports when the block is fully silent.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request is the logical OR of `mute_pin` and `mute_bit`. Either one alone, held high, drives the index to zero and keeps it there.
- R2: The step prescaler counts sample strobes from 0 to STEP_DIV-1 (default 4) and wraps. The strobe that wraps it moves the index one step. While mute is requested, that step goes toward 0, and the index holds once it reaches 0.
- R3: Starting right after reset with code 255 and an index of 255, a mute request held from the first strobe brings the index to 0 on the 1020th strobe and not before.
- R4: With no mute request, the index climbs toward `att_code` one step per STEP_DIV strobes and holds once it equals `att_code`.
- R5: If the request is dropped before the index reaches 0, the index turns and climbs from the value it has reached, at the same step rate.
- R6: On each strobe edge, both outputs are loaded with input × g / 256, truncated toward zero. Here g is the index, except that the maximum index (255) gives g = 256. The index used is its value before that edge's step. `out_valid` is high for exactly the cycle after each strobe.
- R7: `muted` is registered. It is high in a cycle exactly when, in the previous cycle, the index was 0 and mute was requested.
- R8: Synchronous active-high `rst` loads the index from `att_code`, clears the prescaler, and clears both outputs, `out_valid` and `muted`.
- R9: In a cycle without a strobe, the index, the prescaler and both output samples hold their values.
- R10: If `att_code` is changed while unmuted, the index moves toward the new code, up or down, at the step rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| left_in | input | SAMPLE_W | Left signed input sample |
| right_in | input | SAMPLE_W | Right signed input sample |
| att_code | input | ATT_W | Programmed attenuation code (target index) |
| mute_pin | input | 1 | External mute request |
| mute_bit | input | 1 | Control-register mute request |
| left_out | output | SAMPLE_W | Scaled left sample |
| right_out | output | SAMPLE_W | Scaled right sample |
| out_valid | output | 1 | High the cycle after a strobe |
| muted | output | 1 | Fully muted flag |

## Verification
Several rules are checked by assertions on every cycle:
- the index moves by at most one step at a time, and only on a prescaler wrap;
- the index goes down under a mute request and up toward the code when released;
- the prescaler stays in range;
- the outputs stay frozen between strobes;
- a valid output while fully muted is zero.

Other behaviour can only be shown by the bench's scenarios against its own model:
- the exact 1020-strobe fade length;
- a reversal landing on the predicted index;
- rounding toward zero for negative samples;
- unity gain at code 255;
- a retarget after a code change.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } ramp_dir_t;

  // Pick the step direction of the shared gain index.
  function automatic ramp_dir_t pick_dir(input logic req, input logic at_zero,
                                         input logic below, input logic above);
    ramp_dir_t d;
    if (req) d = at_zero ? DIR_HOLD : DIR_DOWN;
    else if (below) d = DIR_UP;
    else if (above) d = DIR_DOWN;
    else d = DIR_HOLD;
    return d;
  endfunction

endpackage

// File: rtl/smr_step_timer.sv
module smr_step_timer #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_stb,
  output logic tick
);
  localparam int CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (smp_stb) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = smp_stb && (cnt == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> $stable(cnt));

endmodule

// File: rtl/smr_gain_index.sv
module smr_gain_index
  import smr_pkg::*;
#(
  parameter int ATT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mute_req,
  input  logic [ATT_W-1:0] att_code,
  output logic [ATT_W-1:0] idx
);
  ramp_dir_t dir;

  always_comb dir = pick_dir(mute_req, idx == '0, idx < att_code, idx > att_code);

  always_ff @(posedge clk) begin
    if (rst) idx <= att_code;
    else if (tick) begin
      case (dir)
        DIR_DOWN: idx <= idx - 1'b1;
        DIR_UP:   idx <= idx + 1'b1;
        default:  idx <= idx;
      endcase
    end
  end

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx)) |-> ((idx == $past(idx) + 1'b1) || (idx + 1'b1 == $past(idx))));

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(idx));

  // R1
  mute_down_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mute_req && idx != '0) |=> (idx == $past(idx) - 1'b1));

  // R4
  rise_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !mute_req && idx < att_code) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int SAMPLE_W = 24,
  parameter int ATT_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [ATT_W-1:0]           idx,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] dout
);
  localparam int GW = ATT_W + 1;
  localparam int PW = SAMPLE_W + GW + 1;
  localparam logic [ATT_W-1:0] IDX_MAX = '1;
  localparam logic [GW-1:0] UNITY = GW'(1 << ATT_W);
  localparam logic signed [PW-1:0] BIAS = PW'((1 << ATT_W) - 1);

  logic [GW-1:0]              gain;
  logic signed [PW-1:0]       prod;
  logic signed [PW-1:0]       biased;
  logic signed [SAMPLE_W-1:0] dnext;

  // Linear lookup: the top index maps to exact unity.
  always_comb gain = (idx == IDX_MAX) ? UNITY : {1'b0, idx};

  always_comb begin
    prod   = $signed({{(PW-SAMPLE_W){din[SAMPLE_W-1]}}, din})
           * $signed({{(PW-GW){1'b0}}, gain});
    biased = prod[PW-1] ? (prod + BIAS) : prod;
    dnext  = SAMPLE_W'(biased >>> ATT_W);
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (load) dout <= dnext;
  end

  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dout));

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int SAMPLE_W = 24,
  parameter int ATT_W    = 8,
  parameter int STEP_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_stb,
  input  logic signed [SAMPLE_W-1:0] left_in,
  input  logic signed [SAMPLE_W-1:0] right_in,
  input  logic [ATT_W-1:0]           att_code,
  input  logic                       mute_pin,
  input  logic                       mute_bit,
  output logic signed [SAMPLE_W-1:0] left_out,
  output logic signed [SAMPLE_W-1:0] right_out,
  output logic                       out_valid,
  output logic                       muted
);
  localparam int NCH = 2;

  logic                       mute_req;
  logic                       tick;
  logic [ATT_W-1:0]           idx;
  logic signed [SAMPLE_W-1:0] ch_in  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out [NCH];

  assign mute_req = mute_pin | mute_bit;

  smr_step_timer #(.STEP_DIV(STEP_DIV)) i_timer (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .tick(tick)
  );

  smr_gain_index #(.ATT_W(ATT_W)) i_index (
    .clk(clk), .rst(rst), .tick(tick), .mute_req(mute_req),
    .att_code(att_code), .idx(idx)
  );

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smr_scaler #(.SAMPLE_W(SAMPLE_W), .ATT_W(ATT_W)) i_scaler (
      .clk(clk), .rst(rst), .load(smp_stb), .idx(idx),
      .din(ch_in[c]), .dout(ch_out[c])
    );
  end

  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      muted     <= 1'b0;
    end else begin
      out_valid <= smp_stb;
      muted     <= mute_req && (idx == '0);
    end
  end

  // R7
  muted_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && muted) |-> (left_out == '0 && right_out == '0));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_stb));

endmodule

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
  localparam int SW = 24;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [SW-1:0] left_in = '0, right_in = '0;
  logic [AW-1:0] att_code = 8'd255;
  logic mute_pin = 1'b0, mute_bit = 1'b0;
  logic signed [SW-1:0] left_out, right_out;
  logic out_valid, muted;

  always #2.5 clk = ~clk;

  soft_mute_ramp #(.SAMPLE_W(SW), .ATT_W(AW), .STEP_DIV(4)) i_soft_mute_ramp (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .left_in(left_in), .right_in(right_in),
    .att_code(att_code), .mute_pin(mute_pin), .mute_bit(mute_bit),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid), .muted(muted)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int m_idx = 255, m_cnt = 0;
  longint e_l = 0, e_r = 0;
  bit e_v = 0, e_m = 0;

  function automatic longint scale(input longint x, input int idx);
    longint g = (idx == 255) ? 256 : idx;
    return (x * g) / 256;
  endfunction

  function automatic logic signed [SW-1:0] rnd_smp();
    return SW'($urandom);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock cycle: model update, edge, compare at the negedge.
  task automatic tick(input bit stb, input string tag);
    bit req;
    smp_stb = stb;
    req = mute_pin | mute_bit;
    if (rst) begin
      e_l = 0; e_r = 0; e_v = 0; e_m = 0; m_idx = att_code; m_cnt = 0;
    end else begin
      e_m = (m_idx == 0) && req;
      e_v = stb;
      if (stb) begin
        e_l = scale(longint'(left_in), m_idx);
        e_r = scale(longint'(right_in), m_idx);
        if (m_cnt == 3) begin
          m_cnt = 0;
          if (req) begin if (m_idx > 0) m_idx--; end
          else if (m_idx < att_code) m_idx++;
          else if (m_idx > att_code) m_idx--;
        end else m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    smp_stb = 1'b0;
    check(longint'(left_out) == e_l, tag, "left_out", longint'(left_out), e_l);
    check(longint'(right_out) == e_r, tag, "right_out", longint'(right_out), e_r);
    check(out_valid == e_v, tag, "out_valid", longint'(out_valid), longint'(e_v));
    check(muted == e_m, tag, "muted", longint'(muted), longint'(e_m));
  endtask

  task automatic strobes(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      left_in = rnd_smp(); right_in = rnd_smp();
      tick(1'b1, tag);
      tick(1'b0, tag);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 3; i++) tick(1'b0, "R8");
    rst = 1'b0;
    check(left_out == 0 && right_out == 0 && !muted && !out_valid, "R8", "reset outputs",
          longint'(left_out), 0);

    // R6: unity at top code, with extremes
    left_in = 24'sh7FFFFF; right_in = 24'sh800000;
    tick(1'b1, "R6");
    check(left_out == 24'sh7FFFFF, "R6", "unity left", longint'(left_out), 8388607);
    check(right_out == 24'sh800000, "R6", "unity right", longint'(right_out), -8388608);
    tick(1'b0, "R9");
    strobes(39, "R6");

    // R3: fade from 255 with prescaler at phase 0
    mute_pin = 1'b1;
    strobes(1019, "R2");
    check(muted == 1'b0, "R3", "muted before 1020th strobe", longint'(muted), 0);
    left_in = rnd_smp(); tick(1'b1, "R3");
    tick(1'b0, "R3");
    check(muted == 1'b1, "R3", "muted after 1020th strobe", longint'(muted), 1);
    strobes(10, "R2");

    // R1: bit alone keeps mute
    mute_bit = 1'b1; mute_pin = 1'b0;
    strobes(8, "R1");
    check(muted == 1'b1, "R1", "muted by bit only", longint'(muted), 1);
    mute_bit = 1'b0;
    strobes(40, "R4");
    check(muted == 1'b0, "R4", "released", longint'(muted), 0);
    strobes(1000, "R4");

    // R5: reverse part-way from index 205
    mute_bit = 1'b1;
    strobes(200, "R5");
    mute_bit = 1'b0;
    strobes(100, "R5");
    left_in = 24'sd1048576; tick(1'b1, "R5");
    check(longint'(left_out) == 942080, "R5", "reversed level 230", longint'(left_out), 942080);
    tick(1'b0, "R5");

    // R10: retarget to 100, then negative rounding toward zero (R6)
    att_code = 8'd100;
    strobes(700, "R10");
    left_in = -24'sd1000; right_in = 24'sd1000; tick(1'b1, "R10");
    check(longint'(left_out) == -390, "R6", "negative truncation", longint'(left_out), -390);
    check(longint'(right_out) == 390, "R10", "retargeted gain", longint'(right_out), 390);
    tick(1'b0, "R10");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 300 == 0) mute_pin = ~mute_pin;
      if ($urandom % 400 == 0) mute_bit = ~mute_bit;
      if ($urandom % 900 == 0) att_code = AW'($urandom);
      left_in = rnd_smp(); right_in = rnd_smp();
      tick(($urandom % 3) == 0, "R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule